// File: doc/BRIEF.md
# Interrupt Controller Host Command Port

This block is the processor-facing register port of an eight-input interrupt controller. The host reaches it through a single address bit, a write strobe, a read strobe and a byte-wide data bus. After reset the port waits for a start-of-setup byte. It then collects between two and four setup bytes and latches the configuration fields they carry: the vector base, the trigger type, standalone or chained operation, the chained-input map or the controller's own chain number, and the mode options. After that it takes run-time commands. These are mask updates, end-of-service notices and the choice of which core register a read returns.

The priority core sits next to this block. It takes the configuration fields, the mask and the one-cycle end-of-service pulse. In return it supplies its pending-request and in-service vectors, which this port returns on reads. Every pin is a plain level or a plain strobe. A strobe is acted on in the cycle it is sampled high, so there is no back-pressure and the host never waits. The bench never raises both strobes in the same cycle.

Top module: `irq_cmd_port`

## Requirements
- R1: While reset is held and after it is released, op_mode, mask, eoi_pulse, rdata and every configuration output are zero.
- R2: A write with a0=0 and data bit 4 set starts setup from any state. It latches level_mode=bit 3, single_mode=bit 1 and the need-fourth-byte flag from bit 0. It zeroes vec_base, slave_map, slave_id and the five mode outputs, clears the mask, selects the request vector for reads and drops op_mode.
- R3: The next a0=1 write after the start byte loads vec_base from data bits 7..3.
- R4: A third byte (a0=1) is taken only when single_mode is 0. It loads slave_map from all eight bits, and slave_id shows bits 2..0 of that byte.
- R5: A fourth byte (a0=1) is taken only when bit 0 of the start byte was 1. It loads nested_mode=bit 4, buffered=bit 3, master_sel=bit 2, auto_eoi=bit 1 and cpu_mode=bit 0. When the byte is skipped these outputs stay 0.
- R6: op_mode rises on the clock edge that takes the last byte the setup needs. A setup is two bytes long when standalone without the fourth byte, three bytes when it has exactly one of the optional bytes, and four bytes when it has both.
- R7: While op_mode is 1, a write with a0=1 loads mask. A write with a0=1 before the first start byte has no effect.
- R8: While op_mode is 1, writing 0x0B at a0=0 makes later a0=0 reads return core_irr, and writing 0x0A makes them return core_isr. A read at a0=1 returns mask.
- R9: While op_mode is 1, writing exactly 0x20 at a0=0 raises eoi_pulse for the single cycle after the write. eoi_pulse stays low at all other times.
- R10: A write at a0=0 with bit 4 clear changes nothing except as given in R8 and R9. This covers every such write during setup and every other byte value once running.
- R11: rdata is a register. It loads on the edge where rd_en is high and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a0 | input | 1 | Address bit of the host access |
| wr_en | input | 1 | Write strobe, one byte per high cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| core_irr | input | 8 | Pending-request vector from the core |
| core_isr | input | 8 | In-service vector from the core |
| op_mode | output | 1 | Setup complete, run-time commands accepted |
| vec_base | output | 5 | Vector base bits |
| level_mode | output | 1 | 1 = level trigger, 0 = edge |
| single_mode | output | 1 | 1 = standalone, 0 = chained |
| slave_map | output | 8 | Inputs that carry a chained controller |
| slave_id | output | 3 | This controller's chain number |
| nested_mode | output | 1 | Special nesting option |
| buffered | output | 1 | Buffered bus option |
| master_sel | output | 1 | Buffered-mode master select |
| auto_eoi | output | 1 | Automatic end-of-service option |
| cpu_mode | output | 1 | Processor family select |
| mask | output | 8 | Interrupt mask |
| eoi_pulse | output | 1 | One-cycle non-specific end-of-service |

## Verification
The hardest situation to reach is a restart in the middle of a setup sequence, combined with stray a0=0 bytes, when the sequence length depends on two flags in the start byte. Here a wrong skip decision puts the port in the wrong state, and that only shows up several bytes later. The random stimulus issues new start bytes with random flag bits at random points in a mixed stream of address-1 bytes, stray commands and reads. Every skip path and every restart point is therefore hit many times. A bench model tracks the expected step and every output after each access.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VEC_W  = BYTE_W - 3;
  localparam int unsigned ID_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE2,
    ST_BYTE3,
    ST_BYTE4,
    ST_RUN
  } seq_state_t;

  typedef struct packed {
    logic              level;
    logic              single;
    logic              need4;
    logic [VEC_W-1:0]  vec_base;
    logic [BYTE_W-1:0] slave_map;
    logic              nested;
    logic              buffered;
    logic              master_sel;
    logic              auto_eoi;
    logic              cpu_mode;
  } setup_cfg_t;
endpackage

// File: rtl/irq_setup_seq.sv
module irq_setup_seq
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              a0,
  input  logic [BYTE_W-1:0] wdata,
  output seq_state_t        state,
  output setup_cfg_t        cfg
);
  logic start_byte;
  assign start_byte = wr_en && !a0 && wdata[4];

  // after the vector byte, choose the next step from the start-byte flags
  function automatic seq_state_t after_vec(input setup_cfg_t c);
    if (!c.single)   return ST_BYTE3;
    else if (c.need4) return ST_BYTE4;
    else             return ST_RUN;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg   <= '0;
    end else if (start_byte) begin
      state      <= ST_BYTE2;
      cfg        <= '0;
      cfg.level  <= wdata[3];
      cfg.single <= wdata[1];
      cfg.need4  <= wdata[0];
    end else if (wr_en && a0) begin
      unique case (state)
        ST_BYTE2: begin
          cfg.vec_base <= wdata[BYTE_W-1:3];
          state        <= after_vec(cfg);
        end
        ST_BYTE3: begin
          cfg.slave_map <= wdata;
          state         <= cfg.need4 ? ST_BYTE4 : ST_RUN;
        end
        ST_BYTE4: begin
          cfg.nested     <= wdata[4];
          cfg.buffered   <= wdata[3];
          cfg.master_sel <= wdata[2];
          cfg.auto_eoi   <= wdata[1];
          cfg.cpu_mode   <= wdata[0];
          state          <= ST_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_run_decode.sv
module irq_run_decode
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              a0,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              running,
  output logic [BYTE_W-1:0] mask,
  output logic              sel_isr,
  output logic              eoi_pulse
);
  localparam logic [BYTE_W-1:0] EOI_CODE = 8'h20;
  localparam logic [BYTE_W-2:0] SEL_CODE = 7'b0000101;

  logic start_byte, cmd_wr;
  assign start_byte = wr_en && !a0 && wdata[4];
  assign cmd_wr     = wr_en && !a0 && !wdata[4] && running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      sel_isr   <= 1'b0;
      eoi_pulse <= 1'b0;
    end else begin
      eoi_pulse <= cmd_wr && (wdata == EOI_CODE);
      if (start_byte) begin
        mask    <= '0;
        sel_isr <= 1'b0;
      end else if (wr_en && a0 && running) begin
        mask <= wdata;
      end else if (cmd_wr && (wdata[BYTE_W-1:1] == SEL_CODE)) begin
        sel_isr <= !wdata[0];
      end
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              a0,
  input  logic              sel_isr,
  input  logic [BYTE_W-1:0] mask,
  input  logic [BYTE_W-1:0] core_irr,
  input  logic [BYTE_W-1:0] core_isr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] pick;
  always_comb begin
    if (a0)           pick = mask;
    else if (sel_isr) pick = core_isr;
    else              pick = core_irr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= pick;
  end
endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a0,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] core_irr,
  input  logic [BYTE_W-1:0] core_isr,
  output logic              op_mode,
  output logic [VEC_W-1:0]  vec_base,
  output logic              level_mode,
  output logic              single_mode,
  output logic [BYTE_W-1:0] slave_map,
  output logic [ID_W-1:0]   slave_id,
  output logic              nested_mode,
  output logic              buffered,
  output logic              master_sel,
  output logic              auto_eoi,
  output logic              cpu_mode,
  output logic [BYTE_W-1:0] mask,
  output logic              eoi_pulse
);
  seq_state_t state;
  setup_cfg_t cfg;
  logic       sel_isr;

  irq_setup_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
    .state(state), .cfg(cfg)
  );

  assign op_mode = (state == ST_RUN);

  irq_run_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
    .running(op_mode), .mask(mask), .sel_isr(sel_isr), .eoi_pulse(eoi_pulse)
  );

  irq_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .a0(a0), .sel_isr(sel_isr),
    .mask(mask), .core_irr(core_irr), .core_isr(core_isr), .rdata(rdata)
  );

  assign vec_base    = cfg.vec_base;
  assign level_mode  = cfg.level;
  assign single_mode = cfg.single;
  assign slave_map   = cfg.slave_map;
  assign slave_id    = cfg.slave_map[ID_W-1:0];
  assign nested_mode = cfg.nested;
  assign buffered    = cfg.buffered;
  assign master_sel  = cfg.master_sel;
  assign auto_eoi    = cfg.auto_eoi;
  assign cpu_mode    = cfg.cpu_mode;
endmodule

// File: rtl/irq_cmd_port_chk.sv
module irq_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a0,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mask,
  input logic       op_mode,
  input logic       eoi_pulse
);
  a_r9_eoi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(wr_en && !a0 && wdata == 8'h20 && op_mode));

  a_r6_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_mode) |-> $past(wr_en && a0));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !a0 && wdata[4]) |=> (mask == 8'h00 && !op_mode));

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_cmd_port irq_cmd_port_chk u_chk (.*);

// File: tb/tb_irq_cmd_port.sv
module tb_irq_cmd_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, a0 = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, core_irr = 0, core_isr = 0;
  logic [7:0] rdata, slave_map, mask;
  logic [4:0] vec_base;
  logic [2:0] slave_id;
  logic op_mode, level_mode, single_mode, nested_mode, buffered, master_sel;
  logic auto_eoi, cpu_mode, eoi_pulse;

  irq_cmd_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  int   m_st;  // 0 idle, 1 byte2, 2 byte3, 3 byte4, 4 running
  logic m_lvl, m_sgl, m_n4, m_sel, m_eoi;
  logic [4:0] m_vec, m_f4;
  logic [7:0] m_map, m_mask, m_rd;

  function automatic void model_reset();
    m_st = 0; m_lvl = 0; m_sgl = 0; m_n4 = 0; m_sel = 0; m_eoi = 0;
    m_vec = 0; m_f4 = 0; m_map = 0; m_mask = 0; m_rd = 0;
  endfunction

  function automatic void model_write(input logic a, input logic [7:0] d);
    m_eoi = 0;
    if (!a && d[4]) begin
      m_st = 1; m_lvl = d[3]; m_sgl = d[1]; m_n4 = d[0];
      m_vec = 0; m_map = 0; m_f4 = 0; m_mask = 0; m_sel = 0;
    end else if (a) begin
      case (m_st)
        1: begin m_vec = d[7:3]; m_st = !m_sgl ? 2 : (m_n4 ? 3 : 4); end
        2: begin m_map = d; m_st = m_n4 ? 3 : 4; end
        3: begin m_f4 = d[4:0]; m_st = 4; end
        4: m_mask = d;
        default: ;
      endcase
    end else if (m_st == 4) begin
      if (d == 8'h20) m_eoi = 1;
      else if (d == 8'h0A) m_sel = 1;
      else if (d == 8'h0B) m_sel = 0;
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R6", "op_mode", op_mode, m_st == 4);
    chk("R2", "level_mode", level_mode, m_lvl);
    chk("R2", "single_mode", single_mode, m_sgl);
    chk("R3", "vec_base", vec_base, m_vec);
    chk("R4", "slave_map", slave_map, m_map);
    chk("R4", "slave_id", slave_id, m_map[2:0]);
    chk("R5", "mode_bits", {nested_mode, buffered, master_sel, auto_eoi, cpu_mode}, m_f4);
    chk("R7", "mask", mask, m_mask);
    chk("R9", "eoi_pulse", eoi_pulse, m_eoi);
    chk("R11", "rdata", rdata, m_rd);
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk); a0 = a; wdata = d; wr_en = 1;
    model_write(a, d);
    @(negedge clk); wr_en = 0;
    check_all();
    m_eoi = 0;
  endtask

  task automatic do_rd(input logic a);
    @(negedge clk);
    core_irr = 8'($urandom); core_isr = 8'($urandom);
    a0 = a; rd_en = 1;
    m_eoi = 0;
    m_rd = a ? m_mask : (m_sel ? core_isr : core_irr);
    @(negedge clk); rd_en = 0;
    check_all();  // R8 read source checked through rdata
  endtask

  task automatic idle_cycle();
    @(negedge clk); check_all();  // R9 pulse gone, R11 rdata held
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    check_all();  // R1 during reset
    rst_n = 1;
    @(negedge clk); check_all();  // R1 after release

    // R7: address-1 write before any start byte is ignored
    do_wr(1, 8'hFF);
    do_wr(0, 8'h20);  // R10/R9 ignored before setup
    // R6: two-byte standalone setup
    do_wr(0, 8'h1A);
    do_wr(0, 8'h0B);  // R10 stray during setup
    do_wr(1, 8'h97);  // R3 vec base
    chk("R6", "two_byte_run", op_mode, 1);
    do_wr(1, 8'h5C); do_rd(1);  // R7/R8 mask readback
    do_rd(0);                   // R8 default request vector
    do_wr(0, 8'h0A); do_rd(0);  // R8 in-service
    do_wr(0, 8'h08); do_rd(0);  // R10 other command keeps select
    do_wr(0, 8'h0B); do_rd(0);
    do_wr(0, 8'h20); idle_cycle();  // R9 single-cycle pulse
    do_wr(0, 8'h21);               // R10 not exact code
    // R6: four-byte chained setup with fourth byte
    do_wr(0, 8'h11); do_wr(1, 8'h20); do_wr(1, 8'h04);
    chk("R6", "not_yet_run", op_mode, 0);
    do_wr(1, 8'h1F);  // R5
    // R6: three-byte chained setup, R5 fourth skipped
    do_wr(0, 8'h10); do_wr(1, 8'h48); do_wr(1, 8'h02);
    // restart mid-setup, R2
    do_wr(0, 8'h13); do_wr(1, 8'hF8); do_wr(0, 8'h19);
    do_wr(1, 8'h10); do_wr(1, 8'h03);

    for (int round = 0; round < 300; round++) begin
      do_wr(0, 8'($urandom) | 8'h10);
      for (int k = 0; k < int'($urandom_range(0, 24)); k++) begin
        case ($urandom_range(0, 6))
          0, 1: do_wr(1, 8'($urandom));
          2: do_wr(0, 8'($urandom) & 8'hEF);
          3: do_wr(0, 8'h20);
          4: do_wr(0, ($urandom_range(0, 1) != 0) ? 8'h0A : 8'h0B);
          5: do_rd(0);
          default: do_rd(1);
        endcase
        if ($urandom_range(0, 7) == 0) idle_cycle();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule